// File: doc/BRIEF.md
# Dual-Port Banked Data Cache Read Front End

This block is the load side of a direct-mapped data cache that accepts two 8-byte reads in every clock cycle. Its data storage is split into eight word-wide banks. Each 64-byte line is spread across all eight banks, one 8-byte word per bank, so two reads to different words of the same line, or to unrelated lines, usually land in different banks and both go ahead at once. The tag store is held twice, one copy per read port, so both reads check residency in the same cycle. Every tag write goes into both copies together, so they always hold the same contents.

When both reads need the same bank for different words, port 0 takes the bank. Port 1 sees its ready signal low and has to hold its request until a later cycle. When both reads name exactly the same 8-byte word, one bank read serves both ports. Each granted read returns its word one cycle later, together with a valid flag and a hit flag taken from that port's own tag copy.

The block does not handle misses and does not choose victims. A separate fill port writes data words into the banks, and a tag write port sets or clears the tag of a line in both copies.

Top module: `dual_port_bank_cache`

## Requirements
- R1: While reset is held and after it is released with no requests, `p1_ready` is 1 and both response valid flags are 0.
- R2: An address is decoded as follows: bits 2:0 are the byte within a word and are ignored; bits 5:3 are the bank; bits 15:6 are the line index; bits 31:16 are the tag. The word returned is the last word written by the fill port to the same bits 15:3.
- R3: A request on port 0 is always accepted. In the next cycle `p0_rsp_valid` is 1 and carries the word and hit flag for that address.
- R4: When both ports request words in different banks, `p1_ready` is 1 and both ports return a response in the next cycle.
- R5: When both ports request different words in the same bank, `p1_ready` is 0 and port 1 gets no response in the next cycle. The same request, offered again with no conflict, is then served normally.
- R6: When both ports request the same word (equal address bits 15:3), `p1_ready` is 1 and both ports return the same data in the next cycle, even if the tag bits differ.
- R7: The hit flag is 1 only when the line index holds a valid entry whose stored tag equals address bits 31:16. On a miss the response is still valid and still carries the bank word.
- R8: A tag write with valid set updates both tag copies, so that later reads of that line from either port report a hit.
- R9: A tag write with valid clear makes later reads of that line report a miss on both ports.
- R10: A fill write and a read of the same word in the same cycle return the old word. Reads in later cycles return the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_req | input | 1 | Port 0 read request |
| p0_addr | input | 32 | Port 0 byte address |
| p1_req | input | 1 | Port 1 read request |
| p1_addr | input | 32 | Port 1 byte address |
| p1_ready | output | 1 | Port 1 request is accepted this cycle |
| p0_rsp_valid | output | 1 | Port 0 response present |
| p0_rsp_hit | output | 1 | Port 0 tag hit |
| p0_rsp_data | output | 64 | Port 0 read word |
| p1_rsp_valid | output | 1 | Port 1 response present |
| p1_rsp_hit | output | 1 | Port 1 tag hit |
| p1_rsp_data | output | 64 | Port 1 read word |
| fill_en | input | 1 | Write one data word into its bank |
| fill_addr | input | 32 | Address of the word being written |
| fill_data | input | 64 | Word to write |
| tag_wr_en | input | 1 | Write one tag entry in both copies |
| tag_wr_addr | input | 32 | Address whose index and tag are written |
| tag_wr_valid | input | 1 | Valid bit stored with the tag |

## Verification
The case that is hardest to reach from the ports is a bank collision sitting next to a shared-word read, because they differ only in address bits 15:6. A shared read that uses a different tag can also miss on one port and hit on the other, while both ports still return the same word. The stimulus sets up two lines in known indices. It then pairs addresses that share only the bank, that share the whole word with equal tags, and that share the word with unequal tags. After a stall it offers the stalled port-1 request again on its own. A fill aimed at a word that is being read in the same cycle checks that the read returns the old contents.

// File: rtl/cab_pkg.sv
package cab_pkg;
   localparam int unsigned CAB_ADDR_W     = 32;
   localparam int unsigned CAB_WORD_BYTES = 8;
   localparam int unsigned CAB_NUM_BANKS  = 8;
   localparam int unsigned CAB_LINE_BYTES = 64;
   localparam int unsigned CAB_SIZE_BYTES = 65536;
   localparam int unsigned CAB_NUM_PORTS  = 2;

   typedef struct packed {
      logic p0;      // port 0 owns a bank this cycle
      logic p1;      // port 1 accepted
      logic shared;  // both ports read one word
   } cab_grant_t;
endpackage

// File: rtl/cab_data_bank.sv
module cab_data_bank #(
   parameter int unsigned ROWS   = 1024,
   parameter int unsigned DATA_W = 64,
   localparam int unsigned ROW_W = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [ROW_W-1:0]  rd_row,
   input  logic              wr_en,
   input  logic [ROW_W-1:0]  wr_row,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [ROWS];

   // Read returns the array contents before this edge's write.
   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= mem[rd_row];
      if (wr_en) mem[wr_row] <= wr_data;
   end
endmodule

// File: rtl/cab_tag_copy.sv
module cab_tag_copy #(
   parameter int unsigned SETS  = 1024,
   parameter int unsigned TAG_W = 16,
   localparam int unsigned IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_en,
   input  logic [IDX_W-1:0] lk_index,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_index,
   input  logic [TAG_W-1:0] upd_tag,
   input  logic             upd_valid
);
   logic [TAG_W-1:0] tag_mem [SETS];
   logic [SETS-1:0]  valid_vec;
   logic [TAG_W-1:0] rd_tag_q, cmp_tag_q;
   logic             rd_valid_q;

   always_ff @(posedge clk) begin
      if (upd_en) tag_mem[upd_index] <= upd_tag;
      if (lk_en) begin
         rd_tag_q  <= tag_mem[lk_index];
         cmp_tag_q <= lk_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_vec  <= '0;
         rd_valid_q <= 1'b0;
      end else begin
         if (upd_en) valid_vec[upd_index] <= upd_valid;
         if (lk_en) rd_valid_q <= valid_vec[lk_index];
      end
   end

   always_comb lk_hit = rd_valid_q && (rd_tag_q == cmp_tag_q);
endmodule

// File: rtl/cab_bank_arbiter.sv
module cab_bank_arbiter
   import cab_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned BANK_LSB  = 3,
   parameter int unsigned ROW_W     = 10,
   localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
   localparam int unsigned ROW_LSB  = BANK_LSB + BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p0_req,
   input  logic [ADDR_W-1:0] p0_addr,
   input  logic              p1_req,
   input  logic [ADDR_W-1:0] p1_addr,
   output cab_grant_t        grant,
   output logic              p1_ready,
   output logic [NUM_BANKS-1:0] bank_rd_en,
   output logic [ROW_W-1:0]  bank_rd_row [NUM_BANKS]
);
   logic [BANK_W-1:0] bank0, bank1;
   logic [ROW_W-1:0]  row0, row1;
   logic              same_bank, same_word, collide;

   always_comb begin
      bank0     = p0_addr[BANK_LSB +: BANK_W];
      bank1     = p1_addr[BANK_LSB +: BANK_W];
      row0      = p0_addr[ROW_LSB +: ROW_W];
      row1      = p1_addr[ROW_LSB +: ROW_W];
      same_bank = (bank0 == bank1);
      same_word = same_bank && (row0 == row1);
      collide   = p0_req && p1_req && same_bank && !same_word;
      p1_ready  = !collide;
      grant.p0     = p0_req;
      grant.p1     = p1_req && !collide;
      grant.shared = p0_req && p1_req && same_word;
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_sel
      logic hit0, hit1;
      always_comb begin
         hit0 = grant.p0 && (bank0 == BANK_W'(b));
         hit1 = grant.p1 && (bank1 == BANK_W'(b));
         bank_rd_en[b]  = hit0 || hit1;
         bank_rd_row[b] = hit0 ? row0 : row1;
      end
   end

   // A bank is never asked for two different rows in one cycle.
   AST_BANK_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (grant.p0 && grant.p1 && (bank0 == bank1)) |-> (row0 == row1)); // R5
   // Port 1 is never refused while port 0 is idle.
   AST_IDLE_P0_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !p0_req |-> p1_ready); // R4
endmodule

// File: rtl/dual_port_bank_cache.sv
module dual_port_bank_cache
   import cab_pkg::*;
#(
   parameter int unsigned ADDR_W     = CAB_ADDR_W,
   parameter int unsigned WORD_BYTES = CAB_WORD_BYTES,
   parameter int unsigned NUM_BANKS  = CAB_NUM_BANKS,
   parameter int unsigned LINE_BYTES = CAB_LINE_BYTES,
   parameter int unsigned SIZE_BYTES = CAB_SIZE_BYTES,
   localparam int unsigned DATA_W    = WORD_BYTES * 8,
   localparam int unsigned BANK_LSB  = $clog2(WORD_BYTES),
   localparam int unsigned BANK_W    = $clog2(NUM_BANKS),
   localparam int unsigned IDX_LSB   = $clog2(LINE_BYTES),
   localparam int unsigned SETS      = SIZE_BYTES / LINE_BYTES,
   localparam int unsigned IDX_W     = $clog2(SETS),
   localparam int unsigned TAG_LSB   = IDX_LSB + IDX_W,
   localparam int unsigned TAG_W     = ADDR_W - TAG_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p0_req,
   input  logic [ADDR_W-1:0] p0_addr,
   input  logic              p1_req,
   input  logic [ADDR_W-1:0] p1_addr,
   output logic              p1_ready,
   output logic              p0_rsp_valid,
   output logic              p0_rsp_hit,
   output logic [DATA_W-1:0] p0_rsp_data,
   output logic              p1_rsp_valid,
   output logic              p1_rsp_hit,
   output logic [DATA_W-1:0] p1_rsp_data,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              tag_wr_en,
   input  logic [ADDR_W-1:0] tag_wr_addr,
   input  logic              tag_wr_valid
);
   // Geometry checks at elaboration.
   if (LINE_BYTES != NUM_BANKS * WORD_BYTES) begin : g_bad_line
      $error("line must hold exactly one word per bank");
   end
   if ((NUM_BANKS & (NUM_BANKS - 1)) != 0 || NUM_BANKS < 2) begin : g_bad_banks
      $error("bank count must be a power of two, at least 2");
   end
   if ((SETS & (SETS - 1)) != 0 || TAG_LSB >= ADDR_W) begin : g_bad_sets
      $error("set count must be a power of two that fits the address");
   end

   cab_grant_t         grant;
   logic [NUM_BANKS-1:0] bank_rd_en;
   logic [IDX_W-1:0]   bank_rd_row [NUM_BANKS];
   logic [DATA_W-1:0]  bank_rd_data [NUM_BANKS];

   cab_bank_arbiter #(
      .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_LSB(BANK_LSB), .ROW_W(IDX_W)
   ) u_arb (
      .clk(clk), .rst_n(rst_n),
      .p0_req(p0_req), .p0_addr(p0_addr), .p1_req(p1_req), .p1_addr(p1_addr),
      .grant(grant), .p1_ready(p1_ready),
      .bank_rd_en(bank_rd_en), .bank_rd_row(bank_rd_row)
   );

   logic [BANK_W-1:0] fill_bank;
   always_comb fill_bank = fill_addr[BANK_LSB +: BANK_W];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      cab_data_bank #(.ROWS(SETS), .DATA_W(DATA_W)) u_bank (
         .clk(clk),
         .rd_en(bank_rd_en[b]), .rd_row(bank_rd_row[b]),
         .wr_en(fill_en && (fill_bank == BANK_W'(b))),
         .wr_row(fill_addr[IDX_LSB +: IDX_W]),
         .wr_data(fill_data),
         .rd_data(bank_rd_data[b])
      );
   end

   // One tag copy per read port, both written together.
   logic              lk_en   [CAB_NUM_PORTS];
   logic [ADDR_W-1:0] lk_addr [CAB_NUM_PORTS];
   logic              lk_hit  [CAB_NUM_PORTS];

   always_comb begin
      lk_en[0]   = grant.p0;
      lk_addr[0] = p0_addr;
      lk_en[1]   = grant.p1;
      lk_addr[1] = p1_addr;
   end

   for (genvar p = 0; p < CAB_NUM_PORTS; p++) begin : g_tag
      cab_tag_copy #(.SETS(SETS), .TAG_W(TAG_W)) u_copy (
         .clk(clk), .rst_n(rst_n),
         .lk_en(lk_en[p]),
         .lk_index(lk_addr[p][IDX_LSB +: IDX_W]),
         .lk_tag(lk_addr[p][TAG_LSB +: TAG_W]),
         .lk_hit(lk_hit[p]),
         .upd_en(tag_wr_en),
         .upd_index(tag_wr_addr[IDX_LSB +: IDX_W]),
         .upd_tag(tag_wr_addr[TAG_LSB +: TAG_W]),
         .upd_valid(tag_wr_valid)
      );
   end

   // Response stage.
   logic [BANK_W-1:0] p0_bank_q, p1_bank_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p0_rsp_valid <= 1'b0;
         p1_rsp_valid <= 1'b0;
         p0_bank_q    <= '0;
         p1_bank_q    <= '0;
      end else begin
         p0_rsp_valid <= grant.p0;
         p1_rsp_valid <= grant.p1;
         if (grant.p0) p0_bank_q <= p0_addr[BANK_LSB +: BANK_W];
         if (grant.p1) p1_bank_q <= p1_addr[BANK_LSB +: BANK_W];
      end
   end

   always_comb begin
      p0_rsp_data = bank_rd_data[p0_bank_q];
      p1_rsp_data = bank_rd_data[p1_bank_q];
      p0_rsp_hit  = p0_rsp_valid && lk_hit[0];
      p1_rsp_hit  = p1_rsp_valid && lk_hit[1];
   end

   AST_P0_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
      p0_req |=> p0_rsp_valid); // R3
   AST_P1_ANSWERS_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (p1_req && p1_ready) |=> p1_rsp_valid); // R4
   AST_P1_SILENT_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !(p1_req && p1_ready) |=> !p1_rsp_valid); // R5
   AST_SHARED_WORD_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_req && p1_req && (p0_addr[TAG_LSB-1:BANK_LSB] == p1_addr[TAG_LSB-1:BANK_LSB]))
      |=> (p1_rsp_valid && (p0_rsp_data == p1_rsp_data))); // R6
   AST_COPIES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_req && p1_req && (p0_addr[ADDR_W-1:IDX_LSB] == p1_addr[ADDR_W-1:IDX_LSB]))
      |=> (p0_rsp_hit == p1_rsp_hit)); // R8
endmodule

// File: tb/sim_dual_port_bank_cache.sv
module sim_dual_port_bank_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        p0_req = 1'b0, p1_req = 1'b0;
   logic [31:0] p0_addr = '0, p1_addr = '0;
   logic        p1_ready;
   logic        p0_rsp_valid, p0_rsp_hit, p1_rsp_valid, p1_rsp_hit;
   logic [63:0] p0_rsp_data, p1_rsp_data;
   logic        fill_en = 1'b0;
   logic [31:0] fill_addr = '0;
   logic [63:0] fill_data = '0;
   logic        tag_wr_en = 1'b0, tag_wr_valid = 1'b0;
   logic [31:0] tag_wr_addr = '0;

   always #10 clk = ~clk;  // 50 MHz

   dual_port_bank_cache u0 (
      .clk(clk), .rst_n(rst_n),
      .p0_req(p0_req), .p0_addr(p0_addr), .p1_req(p1_req), .p1_addr(p1_addr),
      .p1_ready(p1_ready),
      .p0_rsp_valid(p0_rsp_valid), .p0_rsp_hit(p0_rsp_hit), .p0_rsp_data(p0_rsp_data),
      .p1_rsp_valid(p1_rsp_valid), .p1_rsp_hit(p1_rsp_hit), .p1_rsp_data(p1_rsp_data),
      .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
      .tag_wr_en(tag_wr_en), .tag_wr_addr(tag_wr_addr), .tag_wr_valid(tag_wr_valid)
   );

   typedef struct {
      logic [63:0] data;
      logic        hit;
      string       req;
   } exp_t;

   exp_t        q0[$], q1[$];
   int          checks = 0, errors = 0;
   logic [63:0] mdata [logic [12:0]];
   logic        mvalid [1024];
   logic [15:0] mtag [1024];

   function automatic logic [31:0] mk(input logic [15:0] t, input int idx, input int bank);
      return {t, 10'(idx), 3'(bank), 3'b101};
   endfunction

   function automatic logic [63:0] pat(input logic [31:0] a, input int salt);
      return {a, 32'hC0DE_0000 + 32'(salt)};
   endfunction

   function automatic exp_t expect_of(input logic [31:0] a, input string req);
      exp_t e;
      e.data = mdata.exists(a[15:3]) ? mdata[a[15:3]] : 64'h0;
      e.hit  = mvalid[a[15:6]] && (mtag[a[15:6]] == a[31:16]);
      e.req  = req;
      return e;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Monitor: compares the responses of the previous cycle.
   task automatic monitor();
      exp_t e;
      if (q0.size() > 0) begin
         e = q0.pop_front();
         check(p0_rsp_valid === 1'b1, e.req, "p0 valid", 64'(p0_rsp_valid), 64'h1);
         check(p0_rsp_data === e.data, e.req, "p0 data", p0_rsp_data, e.data);
         check(p0_rsp_hit === e.hit, e.req, "p0 hit", 64'(p0_rsp_hit), 64'(e.hit));
      end else if (p0_rsp_valid !== 1'b0)
         check(1'b0, "R3", "p0 unexpected valid", 64'(p0_rsp_valid), 64'h0);
      if (q1.size() > 0) begin
         e = q1.pop_front();
         check(p1_rsp_valid === 1'b1, e.req, "p1 valid", 64'(p1_rsp_valid), 64'h1);
         check(p1_rsp_data === e.data, e.req, "p1 data", p1_rsp_data, e.data);
         check(p1_rsp_hit === e.hit, e.req, "p1 hit", 64'(p1_rsp_hit), 64'(e.hit));
      end else if (p1_rsp_valid !== 1'b0)
         check(1'b0, "R5", "p1 unexpected valid", 64'(p1_rsp_valid), 64'h0);
   endtask

   // Driver: one cycle of stimulus, expectations pushed from the bench model.
   task automatic cyc(input logic v0, input logic [31:0] a0,
                      input logic v1, input logic [31:0] a1, input string req,
                      input logic fe = 1'b0, input logic [31:0] fa = '0,
                      input logic [63:0] fd = '0, input logic te = 1'b0,
                      input logic [31:0] ta = '0, input logic tv = 1'b0);
      logic exp_rdy;
      @(negedge clk);
      monitor();
      p0_req = v0; p0_addr = a0; p1_req = v1; p1_addr = a1;
      fill_en = fe; fill_addr = fa; fill_data = fd;
      tag_wr_en = te; tag_wr_addr = ta; tag_wr_valid = tv;
      #1;
      exp_rdy = !(v0 && v1 && (a0[5:3] == a1[5:3]) && (a0[15:6] != a1[15:6]));
      if (v1)
         check(p1_ready === exp_rdy, req, "p1_ready", 64'(p1_ready), 64'(exp_rdy));
      if (v0) q0.push_back(expect_of(a0, req));
      if (v1 && exp_rdy) q1.push_back(expect_of(a1, req));
      if (fe) mdata[fa[15:3]] = fd;
      if (te) begin
         mvalid[ta[15:6]] = tv;
         mtag[ta[15:6]]   = ta[31:16];
      end
   endtask

   task automatic idle(input string req);
      cyc(1'b0, '0, 1'b0, '0, req);
   endtask

   task automatic fill(input logic [31:0] a, input int salt);
      cyc(1'b0, '0, 1'b0, '0, "R2", 1'b1, a, pat(a, salt));
   endtask

   task automatic tagw(input logic [31:0] a, input logic v);
      cyc(1'b0, '0, 1'b0, '0, "R8", 1'b0, '0, '0, 1'b1, a, v);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] la, lb, lc;
      logic [31:0] a_tmp;
      for (int i = 0; i < 1024; i++) begin
         mvalid[i] = 1'b0;
         mtag[i]   = '0;
      end
      la = mk(16'h0012, 5, 0);
      lb = mk(16'h0034, 9, 0);
      lc = mk(16'h0056, 20, 0);

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(p1_ready === 1'b1, "R1", "p1_ready in reset", 64'(p1_ready), 64'h1);
      check(p0_rsp_valid === 1'b0 && p1_rsp_valid === 1'b0, "R1", "valid in reset",
            64'({p0_rsp_valid, p1_rsp_valid}), 64'h0);
      rst_n = 1'b1;
      idle("R1");
      check(p1_ready === 1'b1, "R1", "p1_ready after reset", 64'(p1_ready), 64'h1);

      // Load lines A, B, C and tags for A and B.
      for (int b = 0; b < 8; b++) begin
         fill(mk(16'h0012, 5, b), b);
         fill(mk(16'h0034, 9, b), 16 + b);
         fill(mk(16'h0056, 20, b), 32 + b);
      end
      tagw(la, 1'b1);
      tagw(lb, 1'b1);

      // R2, R3: port 0 alone across all banks of line A
      for (int b = 0; b < 8; b++) cyc(1'b1, mk(16'h0012, 5, b), 1'b0, '0, "R3");
      // R2: byte bits ignored, bank from bits 5:3
      cyc(1'b1, mk(16'h0012, 5, 6) ^ 32'h7, 1'b0, '0, "R2");

      // R4: different banks, both served
      cyc(1'b1, mk(16'h0012, 5, 1), 1'b1, mk(16'h0034, 9, 2), "R4");
      cyc(1'b1, mk(16'h0034, 9, 7), 1'b1, mk(16'h0012, 5, 0), "R4");
      cyc(1'b0, '0, 1'b1, mk(16'h0034, 9, 4), "R4");

      // R5: same bank, different rows -> stall, then retry alone
      cyc(1'b1, mk(16'h0012, 5, 3), 1'b1, mk(16'h0034, 9, 3), "R5");
      cyc(1'b0, '0, 1'b1, mk(16'h0034, 9, 3), "R5");
      // R5: stall, retry against port 0 in another bank
      cyc(1'b1, mk(16'h0034, 9, 6), 1'b1, mk(16'h0012, 5, 6), "R5");
      cyc(1'b1, mk(16'h0034, 9, 1), 1'b1, mk(16'h0012, 5, 6), "R5");

      // R6: same word, same tag; and same word, different tag (R7 miss)
      cyc(1'b1, mk(16'h0012, 5, 4), 1'b1, mk(16'h0012, 5, 4), "R6");
      cyc(1'b1, mk(16'h0012, 5, 2), 1'b1, mk(16'h0099, 5, 2), "R6");

      // R7: invalid index gives miss with valid data
      cyc(1'b1, mk(16'h0056, 20, 5), 1'b1, mk(16'h0056, 20, 0), "R7");
      // R7: valid index, wrong tag
      cyc(1'b1, mk(16'h0077, 9, 2), 1'b0, '0, "R7");

      // R8: tag write makes both ports hit
      tagw(lc, 1'b1);
      cyc(1'b1, mk(16'h0056, 20, 5), 1'b1, mk(16'h0056, 20, 6), "R8");
      cyc(1'b1, mk(16'h0056, 20, 1), 1'b1, mk(16'h0056, 20, 1), "R8");

      // R9: clearing valid makes both ports miss
      cyc(1'b0, '0, 1'b0, '0, "R9", 1'b0, '0, '0, 1'b1, lb, 1'b0);
      cyc(1'b1, mk(16'h0034, 9, 0), 1'b1, mk(16'h0034, 9, 5), "R9");

      // R10: fill during read returns old data, later read sees new
      a_tmp = mk(16'h0012, 5, 7);
      cyc(1'b1, a_tmp, 1'b1, mk(16'h0012, 5, 3), "R10", 1'b1, a_tmp, 64'hFEED_FACE_1234_5678);
      cyc(1'b1, a_tmp, 1'b0, '0, "R10");
      a_tmp = mk(16'h0034, 9, 2);
      cyc(1'b1, mk(16'h0012, 5, 0), 1'b1, a_tmp, "R10", 1'b1, a_tmp, 64'h0BAD_CAFE_0000_0001);
      cyc(1'b0, '0, 1'b1, a_tmp, "R10");

      idle("R3");
      idle("R3");
      check(q0.size() == 0 && q1.size() == 0, "R3", "queues drained",
            64'(q0.size() + q1.size()), 64'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule